// File: doc/BRIEF.md
# Partitioned Sub-Word SIMD Adder

This block is a 64-bit add/subtract and bitwise logic unit whose carry chain can be split into independent segments. A mode input makes one operand word act as a single 64-bit element, as two 32-bit elements, or as eight 8-bit elements. In each of these modes one pass through the shared datapath produces that many independent sums or differences. The bitwise operations AND, OR and XOR act on the whole word and ignore the mode.

Each operation is presented with an input-valid strobe. The result and the per-element carry-out flags appear one clock later, together with an output-valid strobe. A typical use is one lane of a wide array that steps in lock-step. Packing narrow data eight to a word multiplies the element count per lane.

Top module: `simd_alu`

## Requirements
- R1: While rst_ni is low, result_o, flags_o and valid_o are all zero.
- R2: valid_o equals valid_i delayed by one clock. result_o and flags_o load only on a clock edge where valid_i is high, and otherwise keep their value.
- R3: mode_i = 2'b00 selects one 64-bit element. flags_o[0] is the carry out of bit 63, and flags_o[7:1] are zero.
- R4: mode_i = 2'b01 selects two 32-bit elements. Element 0 is bits 31:0 and element 1 is bits 63:32. No carry passes from bit 31 into bit 32. flags_o[0] and flags_o[1] are the carry outs of the two elements, and flags_o[7:2] are zero.
- R5: mode_i = 2'b10 selects eight 8-bit elements. Element i is bits 8i+7:8i. No carry crosses a byte boundary, and flags_o[i] is the carry out of element i.
- R6: mode_i = 2'b11 is reserved and gives exactly the 64-bit mode results.
- R7: op_i = 3'b000 is ADD: each element becomes a+b modulo its width. op_i = 3'b001 is SUB: each element becomes a-b modulo its width. For SUB, the element's flag is the carry out of a + ~b + 1, which is 1 exactly when a >= b unsigned.
- R8: op_i = 3'b010 (AND), 3'b011 (OR) and 3'b100 (XOR) give the bitwise result over all 64 bits whatever the mode, with flags_o all zero.
- R9: op_i values 3'b101 to 3'b111 give result_o = 0 and flags_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operands and controls are valid this cycle |
| mode_i | input | 2 | Element partitioning select |
| op_i | input | 3 | Operation select |
| a_i | input | 64 | First operand word |
| b_i | input | 64 | Second operand word |
| valid_o | output | 1 | Result valid, one cycle after valid_i |
| result_o | output | 64 | Registered result word |
| flags_o | output | 8 | Per-element carry-out flags, element 0 in bit 0 |

## Verification
The same all-ones-plus-one style operands are applied in every mode. In that pattern the carry ripples across the full word in 64-bit mode but must stop at bit 31 or at each byte in the narrower modes, so a leaked carry or a misplaced flag shows at once. Subtraction is tried with operands that are greater, equal and smaller per element, which separates borrow handling from plain inversion. The logic operations are repeated under each mode with mixed bit patterns to show that the mode has no effect on them. A hold test changes the operands while valid_i is low and checks that the registered outputs do not move.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;
  typedef enum logic [1:0] {
    MODE_W64 = 2'b00,
    MODE_W32 = 2'b01,
    MODE_B8  = 2'b10,
    MODE_RSV = 2'b11
  } mode_e;

  typedef enum logic [2:0] {
    OP_ADD = 3'b000,
    OP_SUB = 3'b001,
    OP_AND = 3'b010,
    OP_OR  = 3'b011,
    OP_XOR = 3'b100
  } op_e;
endpackage

// File: rtl/simd_slice_add.sv
module simd_slice_add #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  logic [W:0] full;
  assign full   = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
  assign sum_o  = full[W-1:0];
  assign cout_o = full[W];
endmodule

// File: rtl/simd_seg_ctrl.sv
module simd_seg_ctrl
  import simd_alu_pkg::*;
#(
  parameter int unsigned NUM_SLICE = 8
) (
  input  mode_e                mode_i,
  output logic [NUM_SLICE-1:0] seg_start_o
);
  localparam int unsigned HALF = NUM_SLICE / 2;

  // a slice starts a new element when its carry-in must be cut
  always_comb begin
    for (int i = 0; i < NUM_SLICE; i++) begin
      seg_start_o[i] = (i == 0) || (mode_i == MODE_B8) ||
                       ((mode_i == MODE_W32) && (i == HALF));
    end
  end
endmodule

// File: rtl/simd_alu.sv
module simd_alu
  import simd_alu_pkg::*;
#(
  parameter  int unsigned DATA_W    = 64,
  parameter  int unsigned SLICE_W   = 8,
  localparam int unsigned NUM_SLICE = DATA_W / SLICE_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic [1:0]           mode_i,
  input  logic [2:0]           op_i,
  input  logic [DATA_W-1:0]    a_i,
  input  logic [DATA_W-1:0]    b_i,
  output logic                 valid_o,
  output logic [DATA_W-1:0]    result_o,
  output logic [NUM_SLICE-1:0] flags_o
);
  localparam int unsigned HALF = NUM_SLICE / 2;

  mode_e                mode;
  op_e                  op;
  logic                 is_sub, is_arith;
  logic [DATA_W-1:0]    b_eff, sum;
  logic [NUM_SLICE-1:0] seg_start, cin, cout;
  logic [DATA_W-1:0]    res_n;
  logic [NUM_SLICE-1:0] flag_n;

  assign mode     = mode_e'(mode_i);
  assign op       = op_e'(op_i);
  assign is_sub   = (op == OP_SUB);
  assign is_arith = (op == OP_ADD) || is_sub;
  assign b_eff    = is_sub ? ~b_i : b_i;

  simd_seg_ctrl #(.NUM_SLICE(NUM_SLICE)) u_seg (
    .mode_i      (mode),
    .seg_start_o (seg_start)
  );

  for (genvar g = 0; g < NUM_SLICE; g++) begin : g_slice
    if (g == 0) begin : g_first
      assign cin[g] = seg_start[g] & is_sub;
    end else begin : g_rest
      assign cin[g] = seg_start[g] ? is_sub : cout[g-1];
    end
    simd_slice_add #(.W(SLICE_W)) u_add (
      .a_i    (a_i[g*SLICE_W +: SLICE_W]),
      .b_i    (b_eff[g*SLICE_W +: SLICE_W]),
      .cin_i  (cin[g]),
      .sum_o  (sum[g*SLICE_W +: SLICE_W]),
      .cout_o (cout[g])
    );
  end

  always_comb begin
    flag_n = '0;
    if (is_arith) begin
      unique case (mode)
        MODE_B8:  flag_n = cout;
        MODE_W32: begin
          flag_n[0] = cout[HALF-1];
          flag_n[1] = cout[NUM_SLICE-1];
        end
        default:  flag_n[0] = cout[NUM_SLICE-1];
      endcase
    end
  end

  always_comb begin
    case (op)
      OP_ADD, OP_SUB: res_n = sum;
      OP_AND:         res_n = a_i & b_i;
      OP_OR:          res_n = a_i | b_i;
      OP_XOR:         res_n = a_i ^ b_i;
      default:        res_n = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
      flags_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o <= res_n;
        flags_o  <= flag_n;
      end
    end
  end
endmodule

// File: rtl/simd_alu_chk.sv
module simd_alu_chk #(
  parameter int unsigned DATA_W    = 64,
  parameter int unsigned SLICE_W   = 8,
  parameter int unsigned NUM_SLICE = 8
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 valid_i,
  input logic [1:0]           mode_i,
  input logic [2:0]           op_i,
  input logic [DATA_W-1:0]    a_i,
  input logic [DATA_W-1:0]    b_i,
  input logic                 valid_o,
  input logic [DATA_W-1:0]    result_o,
  input logic [NUM_SLICE-1:0] flags_o
);
  // R2
  valid_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  // R2
  valid_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  // R2
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(result_o) && $stable(flags_o)));
  // R3
  w64_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (mode_i == 2'b00 || mode_i == 2'b11)) |=> (flags_o[NUM_SLICE-1:1] == '0));
  // R4
  w32_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i == 2'b01) |=> (flags_o[NUM_SLICE-1:2] == '0));
  // R7
  lane0_add_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'b000) |=>
      (result_o[SLICE_W-1:0] == $past(a_i[SLICE_W-1:0] + b_i[SLICE_W-1:0])));
  // R8
  and_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'b010) |=> (result_o == $past(a_i & b_i)));
  // R8
  logic_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (op_i == 3'b010 || op_i == 3'b011 || op_i == 3'b100)) |=> (flags_o == '0));
  // R9
  rsv_op_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i > 3'b100) |=> (result_o == '0 && flags_o == '0));
endmodule

bind simd_alu simd_alu_chk #(
  .DATA_W(DATA_W), .SLICE_W(SLICE_W), .NUM_SLICE(NUM_SLICE)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .mode_i(mode_i),
  .op_i(op_i), .a_i(a_i), .b_i(b_i), .valid_o(valid_o),
  .result_o(result_o), .flags_o(flags_o)
);

// File: tb/tb_simd_alu.sv
module tb_simd_alu;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [1:0]  mode_i = '0;
  logic [2:0]  op_i = '0;
  logic [63:0] a_i = '0, b_i = '0;
  logic        valid_o;
  logic [63:0] result_o;
  logic [7:0]  flags_o;
  int total = 0, bad = 0;

  always #2.5 clk_i = ~clk_i;

  simd_alu dut (.*);

  function automatic void model(input logic [63:0] a, input logic [63:0] b,
                                input logic [1:0] m, input logic [2:0] op,
                                output logic [63:0] r, output logic [7:0] f);
    int ew, n;
    logic [64:0] ea, eb, s, mask;
    ew = (m == 2'b01) ? 32 : (m == 2'b10) ? 8 : 64;
    n = 64 / ew;
    r = '0; f = '0;
    mask = (65'd1 << ew) - 65'd1;
    case (op)
      3'b010: r = a & b;
      3'b011: r = a | b;
      3'b100: r = a ^ b;
      3'b000, 3'b001: begin
        for (int e = 0; e < n; e++) begin
          ea = '0; eb = '0;
          for (int k = 0; k < ew; k++) begin
            ea[k] = a[e*ew+k];
            eb[k] = b[e*ew+k];
          end
          if (op == 3'b001) s = ea + ((~eb) & mask) + 65'd1;
          else s = ea + eb;
          for (int k = 0; k < ew; k++) r[e*ew+k] = s[k];
          f[e] = s[ew];
        end
      end
      default: ;
    endcase
  endfunction

  task automatic check(input string req, input logic [63:0] er, input logic [7:0] ef,
                       input logic ev);
    total++;
    if (result_o !== er || flags_o !== ef || valid_o !== ev) begin
      bad++;
      $display("FAIL %s: got r=%h f=%h v=%b exp r=%h f=%h v=%b",
               req, result_o, flags_o, valid_o, er, ef, ev);
    end
  endtask

  task automatic issue(input string req, input logic [63:0] a, input logic [63:0] b,
                       input logic [1:0] m, input logic [2:0] op);
    logic [63:0] er;
    logic [7:0]  ef;
    model(a, b, m, op, er, ef);
    @(negedge clk_i);
    a_i = a; b_i = b; mode_i = m; op_i = op; valid_i = 1'b1;
    @(negedge clk_i);
    check(req, er, ef, 1'b1);
    valid_i = 1'b0;
  endtask

  task automatic t_reset;
    #1;
    check("R1", '0, '0, 1'b0);
    repeat (3) @(negedge clk_i);
    check("R1", '0, '0, 1'b0);
    rst_ni = 1'b1;
  endtask

  task automatic t_w64;
    issue("R3", 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 2'b00, 3'b000);
    check("R3 known", 64'h0, 8'h01, 1'b1);
    issue("R3", 64'h0123_4567_89AB_CDEF, 64'h1111_2222_3333_4444, 2'b00, 3'b000);
  endtask

  task automatic t_w32;
    issue("R4", 64'h0000_0001_FFFF_FFFF, 64'h0000_0000_0000_0001, 2'b01, 3'b000);
    check("R4 known", 64'h0000_0001_0000_0000, 8'h01, 1'b1);
    issue("R4", 64'hFFFF_FFFF_8000_0000, 64'h0000_0001_8000_0000, 2'b01, 3'b000);
  endtask

  task automatic t_b8;
    issue("R5", 64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101, 2'b10, 3'b000);
    check("R5 known", 64'h0, 8'hFF, 1'b1);
    issue("R5", 64'h80FF_7F01_00FE_C040, 64'h8001_7F01_0002_4040, 2'b10, 3'b000);
  endtask

  task automatic t_rsv_mode;
    issue("R6", 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 2'b11, 3'b000);
    check("R6 known", 64'h0, 8'h01, 1'b1);
  endtask

  task automatic t_sub;
    issue("R7", 64'h0705_0000_FF10_0001, 64'h0507_0000_10FF_0100, 2'b10, 3'b001);
    issue("R7", 64'h0000_0005_0000_0000, 64'h0000_0005_0000_0001, 2'b01, 3'b001);
    check("R7 known", 64'h0000_0000_FFFF_FFFF, 8'h02, 1'b1);
    issue("R7", 64'h0, 64'h1, 2'b00, 3'b001);
    check("R7 known", 64'hFFFF_FFFF_FFFF_FFFF, 8'h00, 1'b1);
  endtask

  task automatic t_logic;
    for (int m = 0; m < 4; m++) begin
      issue("R8", 64'hF0F0_FFFF_0000_1234, 64'hFF00_0F0F_FFFF_4321, 2'(m), 3'b010);
      issue("R8", 64'hF0F0_FFFF_0000_1234, 64'hFF00_0F0F_FFFF_4321, 2'(m), 3'b011);
      issue("R8", 64'hF0F0_FFFF_0000_1234, 64'hFF00_0F0F_FFFF_4321, 2'(m), 3'b100);
    end
  endtask

  task automatic t_rsv_op;
    for (int o = 5; o < 8; o++) begin
      issue("R9", 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 2'b10, 3'(o));
    end
  endtask

  task automatic t_hold;
    issue("R2", 64'h1234, 64'h1111, 2'b00, 3'b000);
    @(negedge clk_i);
    a_i = 64'hDEAD; b_i = 64'hBEEF; op_i = 3'b100; mode_i = 2'b10;
    repeat (2) @(negedge clk_i);
    check("R2 hold", 64'h2345, 8'h00, 1'b0);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_w64();
        t_w32();
        t_b8();
        t_rsv_mode();
        t_sub();
        t_logic();
        t_rsv_op();
        t_hold();
      end
      begin
        repeat (5000) @(posedge clk_i);
        total++; bad++;
        $display("FAIL watchdog: got timeout exp completion");
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule